// File: doc/BRIEF.md
# Sequential Low-Word Multiplier with Short-Operand Early Exit

This block multiplies two 32-bit integers and returns the least significant 32 bits of the product. It handles one multiplier bit per clock, using a shift-and-add step. A valid/ready handshake accepts each request. The block then spends one cycle classifying the request and runs a counted series of steps. It raises a one-cycle result strobe at the end. Only one operation is in flight at any time.

The `signed_mode` input decides when an operation can end early. The test looks at `op_a` alone and never compares or swaps the two operands. If `op_a` can be written as a 12-bit value, only 12 steps run; otherwise 32 steps run. A 12-bit value means zero-extended in unsigned mode and sign-extended in signed mode.

Signed and unsigned requests produce the same low word, so no pass fixes the signs of negative operands. On the final step of a signed request, the block subtracts the shifted multiplicand instead of adding it. This gives the top processed bit its negative weight. On a full 32-step run that subtraction has the same effect modulo 2^32 as an addition. On a 12-step run it makes the short path exact for negative operands.

Top module: `iter_mul`

## Requirements
- R1: In the cycle `out_valid` is high, `result` equals (op_a × op_b) mod 2^32 for the operands accepted with that request, in both modes.
- R2: After reset, `in_ready` is 1 and `out_valid` is 0.
- R3: A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the following cycle `in_ready` stays 0 until the cycle after the `out_valid` strobe, when it is 1 again.
- R4: Each accepted request produces exactly one cycle of `out_valid` = 1.
- R5: With `signed_mode` = 0, `out_valid` rises 14 clock edges after the accepting edge when op_a[31:12] is all zero, and 34 edges after it otherwise.
- R6: With `signed_mode` = 1, `out_valid` rises 14 clock edges after the accepting edge when op_a[31:11] is all zeros or all ones, and 34 edges after it otherwise.
- R7: The latency depends on `op_a` and `signed_mode` only. Any value of `op_b`, including all ones, leaves it unchanged.
- R8: For the same operand bit patterns, `result` is identical with `signed_mode` at 0 and at 1.
- R9: `in_valid` and operand changes while an operation is in flight are ignored. The running result is unaffected, and no extra strobe or acceptance follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept a request |
| signed_mode | input | 1 | 1 selects the signed early-exit test, 0 the unsigned one |
| op_a | input | 32 | Multiplier operand, the one tested for the short path |
| op_b | input | 32 | Multiplicand operand |
| out_valid | output | 1 | One-cycle strobe marking a valid result |
| result | output | 32 | Low 32 bits of the product |

## Verification
The bound checker checks a set of properties on every cycle:
- the result word against a product formed from the operands it captured itself;
- the edge count from acceptance to strobe, against 14 or 34 as the operand class dictates;
- the one-cycle strobe;
- `in_ready` dropping after acceptance and returning after the strobe.

Other behaviour can only be shown by the bench's scenarios. These are:
- the values that appear after reset;
- equality of the two modes' results for the same operands;
- requests presented while busy being ignored.

The bench sweeps operands densely around the 12-bit boundaries in both modes, crossed with extreme multiplicands, and adds a pseudo-random series.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_STEP  = 2'd2,
    ST_DONE  = 2'd3
  } mul_state_e;
endpackage

// File: rtl/mul_short_detect.sv
module mul_short_detect #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic             signed_mode,
  output logic             is_short
);
  localparam int UHI = WIDTH - SHORT_BITS;      // bits above the short field
  localparam int SHI = WIDTH - SHORT_BITS + 1;  // those bits plus the short sign bit

  logic [UHI-1:0] upper_u;
  logic [SHI-1:0] upper_s;

  assign upper_u = opnd[WIDTH-1:SHORT_BITS];
  assign upper_s = opnd[WIDTH-1:SHORT_BITS-1];

  always_comb begin
    if (signed_mode) is_short = (&upper_s) | ~(|upper_s);
    else             is_short = ~(|upper_u);
  end
endmodule

// File: rtl/mul_step_ctr.sv
module mul_step_ctr #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic is_short,
  input  logic dec,
  output logic last
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = is_short ? CW'(SHORT_BITS) : CW'(WIDTH);
    else if (dec) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load | dec) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             signed_mode,
  input  logic             step_en,
  input  logic             last_step,
  output logic [WIDTH-1:0] mplier,
  output logic             sgn,
  output logic [WIDTH-1:0] acc
);
  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] acc_d;

  always_comb begin
    addend = mplier[0] ? mcand : '0;
    if (last_step && sgn) acc_d = acc - addend;  // top bit carries negative weight
    else                  acc_d = acc + addend;  // carry out of the MSB dropped
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplier <= '0;
      mcand  <= '0;
      acc    <= '0;
      sgn    <= 1'b0;
    end else if (capture) begin
      mplier <= op_a;
      mcand  <= op_b;
      acc    <= '0;
      sgn    <= signed_mode;
    end else if (step_en) begin
      mplier <= mplier >> 1;
      mcand  <= mcand << 1;
      acc    <= acc_d;
    end
  end
endmodule

// File: rtl/iter_mul.sv
module iter_mul #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] result
);
  import mul_pkg::*;

  mul_state_e       state_q, state_d;
  logic             accept;
  logic             step_en;
  logic             last;
  logic             is_short;
  logic             sgn;
  logic [WIDTH-1:0] mplier;

  assign accept  = in_valid && (state_q == ST_IDLE);
  assign step_en = (state_q == ST_STEP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (in_valid) state_d = ST_CHECK;
      ST_CHECK: state_d = ST_STEP;
      ST_STEP:  if (last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (accept),
    .op_a        (op_a),
    .op_b        (op_b),
    .signed_mode (signed_mode),
    .step_en     (step_en),
    .last_step   (last),
    .mplier      (mplier),
    .sgn         (sgn),
    .acc         (result)
  );

  mul_short_detect #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_det (
    .opnd        (mplier),
    .signed_mode (sgn),
    .is_short    (is_short)
  );

  mul_step_ctr #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state_q == ST_CHECK),
    .is_short (is_short),
    .dec      (step_en),
    .last     (last)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int WIDTH      = 32,
  parameter int SHORT_BITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             signed_mode,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             out_valid,
  input logic [WIDTH-1:0] result
);
  localparam int LW = $clog2(WIDTH + 4);

  logic             busy;
  logic [WIDTH-1:0] ref_prod;
  logic [LW-1:0]    lat_cnt;
  logic [LW-1:0]    exp_lat;
  logic             fits;

  always_comb begin
    if (signed_mode)
      fits = (op_a[WIDTH-1:SHORT_BITS-1] == '0) || (op_a[WIDTH-1:SHORT_BITS-1] == '1);
    else
      fits = (op_a[WIDTH-1:SHORT_BITS] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ref_prod <= '0;
      lat_cnt  <= '0;
      exp_lat  <= '0;
    end else if (in_valid && in_ready) begin
      busy     <= 1'b1;
      ref_prod <= op_a * op_b;
      lat_cnt  <= LW'(1);
      exp_lat  <= fits ? LW'(SHORT_BITS + 2) : LW'(WIDTH + 2);
    end else if (out_valid) begin
      busy <= 1'b0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + LW'(1);
    end
  end

  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result == ref_prod)); // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R3
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4
  AST_DONE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy); // R4
  AST_STEP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_cnt == exp_lat)); // R5, R6
endmodule

bind iter_mul mul_checker #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .signed_mode (signed_mode),
  .op_a        (op_a),
  .op_b        (op_b),
  .out_valid   (out_valid),
  .result      (result)
);

// File: tb/sim_iter_mul.sv
module sim_iter_mul;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic        signed_mode;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  iter_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .signed_mode(signed_mode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [31:0] a, input bit sm);
    bit fit;
    if (sm) fit = (a[31:11] == 21'h0) || (a[31:11] == 21'h1FFFFF);
    else    fit = (a[31:12] == 20'h0);
    return fit ? 14 : 34;
  endfunction

  // Run one operation. junk=1 keeps in_valid high with other operands while busy.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sm,
                        input bit junk, input string lat_tag, output logic [31:0] res);
    int cyc;
    logic [31:0] expv;
    expv = a * b;
    @(negedge clk);
    op_a = a; op_b = b; signed_mode = sm; in_valid = 1'b1;
    @(negedge clk);
    cyc = 1;
    chk(in_ready == 1'b0, "R3 busy", {31'b0, in_ready}, 32'h0);
    if (junk) begin
      op_a = ~a; op_b = b + 32'd77; signed_mode = ~sm;
    end else begin
      in_valid = 1'b0;
    end
    while (!out_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    res = result;
    chk(result == expv, junk ? "R9 result" : "R1 result", result, expv);
    chk(cyc == exp_latency(a, sm), lat_tag, cyc, exp_latency(a, sm));
    @(negedge clk);
    chk(out_valid == 1'b0, junk ? "R9 strobe" : "R4 strobe", {31'b0, out_valid}, 32'h0);
    chk(in_ready == 1'b1, "R3 ready", {31'b0, in_ready}, 32'h1);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1, seed;
    logic [31:0] avals [10];
    logic [31:0] bvals [8];
    avals = '{32'd2047, 32'd2048, 32'hFFFFF800, 32'hFFFFF7FF, 32'd4095,
              32'd4096, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'd0};
    bvals = '{32'd0, 32'd1, 32'hFFFFFFFF, 32'd3, 32'h12345678,
              32'h80000000, 32'hFFFFFFF9, 32'h7FFFFFFF};
    in_valid = 1'b0; signed_mode = 1'b0; op_a = '0; op_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2: values after reset
    chk(in_ready == 1'b1, "R2 ready", {31'b0, in_ready}, 32'h1);
    chk(out_valid == 1'b0, "R2 strobe", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready after release", {31'b0, in_ready}, 32'h1);

    // R5/R6: sweep around the short boundaries
    for (int m = 0; m < 2; m++) begin
      for (int bi = 0; bi < 8; bi++) begin
        for (int ai = -20; ai <= 20; ai++)
          run_op(32'(ai), bvals[bi], m[0], 1'b0, m[0] ? "R6 latency" : "R5 latency", r0);
        for (int ai = 0; ai < 10; ai++)
          run_op(avals[ai], bvals[bi], m[0], 1'b0, m[0] ? "R6 latency" : "R5 latency", r0);
      end
    end

    // R7: wide op_b does not lengthen a short op_a
    run_op(32'd5, 32'hFFFFFFFF, 1'b0, 1'b0, "R7 latency", r0);
    run_op(32'hFFFFFFFE, 32'h80000001, 1'b1, 1'b0, "R7 latency", r0);

    // R8: both modes give the same word for the same bits
    for (int ai = 0; ai < 10; ai++) begin
      run_op(avals[ai], 32'hFFFFFFF9, 1'b0, 1'b0, "R5 latency", r0);
      run_op(avals[ai], 32'hFFFFFFF9, 1'b1, 1'b0, "R6 latency", r1);
      chk(r0 == r1, "R8 mode equality", r1, r0);
    end

    // R9: requests held during an operation are ignored
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, "R6 latency", r0);
    run_op(32'h00012345, 32'h00000777, 1'b0, 1'b1, "R5 latency", r0);

    // pseudo-random series
    seed = 32'h1BADB002;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      seed = nxt(seed); a = seed;
      if (k % 3 == 0) a = {{20{a[11]}}, a[11:0]};
      seed = nxt(seed); b = seed;
      run_op(a, b, k[0], 1'b0, k[0] ? "R6 latency" : "R5 latency", r0);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule